// File: doc/BRIEF.md
# Cascadable LCD Column Driver Front End

This block is the digital half of a 240-column LCD driver. Pixel data arrives on a parallel bus that is 8 bits or 4 bits wide, chosen at run time. On each falling edge of the data clock, one group of bits is written into a 240-bit capture register. A fill-direction input selects whether the register fills upward from the first column or downward from the last one. Several devices can share one bus in a daisy chain. A device captures only while its active-low enable input is low. When its register is full, it pulls its enable output low and so hands the bus to the next device. A falling edge of the load strobe copies the capture register into an output latch. The same edge also rearms the capture sequence and releases the enable output.

The two enable pins are bidirectional, and the fill direction swaps their roles. In each direction one pin listens and the other drives. For each column the block produces a 2-bit drive-level code. The code is selected by the latched pixel bit, the frame alternation input and a display-off input. The analog switches that apply the four voltages sit outside this block.

All strobes are sampled by a system clock `clk`, and falling edges are detected inside the block. A three-state controller sequences capture: READY (pointer at zero), FILL (part of the groups taken) and FULL (register complete, enable output low). The transitions are:
- FIRST_GROUP: READY to FILL.
- LAST_GROUP: READY or FILL to FULL.
- REARM: any state to READY on a load edge.

Top module: `lcd_col_driver`

## Requirements
- R1: With `bus_wide`=1 and `dir_asc`=1, the register fills from column 1 upward, 8 columns per data-clock edge. Group g (0-based) writes columns 8g+1 to 8g+8, and column 8g+1+k takes `din[k]`.
- R2: With `dir_asc`=0, the register fills from column 240 downward. The j-th column written in group g is column 240-W·g-j, and it takes `din[j]`, where W is 8 or 4. Read in ascending column order inside a group, this gives D7..D0 (or D3..D0).
- R3: With `bus_wide`=0, each edge writes 4 columns from `din[3:0]`, following the same direction rule. The values on `din[7:4]` have no effect, and a full register takes 60 edges instead of 30.
- R4: A data-clock falling edge captures only while the enable input pin is low. While that pin is high, the edges change nothing.
- R5: After the last group is captured, the enable output pin goes low and stays low. Further data-clock edges change nothing until the next load edge.
- R6: A load falling edge copies the capture register into the output latch, returns the capture pointer to the first group and drives the enable output pin high.
- R7: The output latch, and so `level_o`, is unaffected by data-clock activity between load edges.
- R8: With `disp_on`=1, column i+1 drives `level_o[2i+1:2i]` as follows: `m_alt`=1 with bit 1 gives 2'b00 (V0), `m_alt`=1 with bit 0 gives 2'b01 (V2), `m_alt`=0 with bit 0 gives 2'b10 (V3), and `m_alt`=0 with bit 1 gives 2'b11 (V5).
- R9: With `disp_on`=0, every column drives 2'b11 (V5), whatever the latch and `m_alt` hold.
- R10: With `dir_asc`=0, `eio_a` is the enable input and `eio_b` drives the enable output. With `dir_asc`=1 the roles are swapped. The input-role pin is left undriven.
- R11: Asynchronous reset clears the capture register and the latch and drives the enable output high.
- R12: If a load edge and a data-clock edge fall in the same clock cycle, the load wins. No group is captured, and the next full register again takes the full count of edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| cp | input | 1 | Data clock; its falling edge captures one group |
| load | input | 1 | Load strobe; its falling edge latches and rearms |
| din | input | BUS_W | Parallel pixel data |
| bus_wide | input | 1 | 1: full bus width, 0: low half only |
| dir_asc | input | 1 | 1: fill from column 1 upward, 0: from the last column downward |
| m_alt | input | 1 | Frame alternation signal |
| disp_on | input | 1 | 0 forces every column to V5 |
| eio_a | inout | 1 | Enable pin A (input when `dir_asc`=0) |
| eio_b | inout | 1 | Enable pin B (input when `dir_asc`=1) |
| level_o | output | 2*NUM_OUT | Drive-level codes, column i+1 at bits [2i+1:2i] |

## Verification
The assertions assume that `cp` and `load` are synchronous to `clk` and held for more than one clock. They also assume that `bus_wide` and `dir_asc` change only while the controller sits at the first group, so that the pointer never lies beyond the last group of the current width. The stimulus drives every strobe at the falling edge of `clk` and holds each level for two clocks. It changes width and direction only right after a load edge. Near-exhaustive sweeps cover all four width and direction settings with computed data patterns. In narrow mode the upper bus half carries non-zero values.

// File: rtl/lcd_col_pkg.sv
package lcd_col_pkg;

    // Drive-level code presented for each column
    typedef enum logic [1:0] {
        LVL_V0 = 2'b00,
        LVL_V2 = 2'b01,
        LVL_V3 = 2'b10,
        LVL_V5 = 2'b11
    } drive_lvl_e;

    // Capture sequencing states
    typedef enum logic [1:0] {
        ST_READY = 2'b00,
        ST_FILL  = 2'b01,
        ST_FULL  = 2'b10
    } fill_state_e;

endpackage

// File: rtl/lcd_col_ctrl.sv
module lcd_col_ctrl
    import lcd_col_pkg::*;
#(
    parameter int NUM_OUT = 240,
    parameter int BUS_W   = 8,
    parameter int PTR_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cp,
    input  logic             load,
    input  logic             ein_n,
    input  logic             wide,
    output logic             cap_en,
    output logic [PTR_W-1:0] ptr,
    output logic             eout_n,
    output logic             load_fall
);

    localparam int NARROW_W   = BUS_W / 2;
    localparam int GRP_WIDE   = NUM_OUT / BUS_W;
    localparam int GRP_NARROW = NUM_OUT / NARROW_W;
    localparam logic [PTR_W-1:0] LAST_WIDE   = PTR_W'(GRP_WIDE - 1);
    localparam logic [PTR_W-1:0] LAST_NARROW = PTR_W'(GRP_NARROW - 1);

    fill_state_e state, state_nx;
    logic        cp_q, load_q;
    logic        cp_fall;
    logic        last_grp;

    // Strobe edge detection in the clk domain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cp_q   <= 1'b0;
            load_q <= 1'b0;
        end else begin
            cp_q   <= cp;
            load_q <= load;
        end
    end

    assign cp_fall   = cp_q & ~cp;
    assign load_fall = load_q & ~load;
    assign last_grp  = (ptr == (wide ? LAST_WIDE : LAST_NARROW));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_READY;
        end else begin
            state <= state_nx;
        end
    end

    // Output process
    always_comb begin
        cap_en = 1'b0;
        eout_n = 1'b1;
        unique case (state)
            ST_READY, ST_FILL: cap_en = cp_fall & ~ein_n & ~load_fall;
            ST_FULL:           eout_n = 1'b0;
            default:           cap_en = 1'b0;
        endcase
    end

    // Transitions: FIRST_GROUP, LAST_GROUP, REARM
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_READY: begin
                if (load_fall)                 state_nx = ST_READY;
                else if (cap_en && last_grp)   state_nx = ST_FULL;
                else if (cap_en)               state_nx = ST_FILL;
            end
            ST_FILL: begin
                if (load_fall)                 state_nx = ST_READY;
                else if (cap_en && last_grp)   state_nx = ST_FULL;
            end
            ST_FULL: begin
                if (load_fall)                 state_nx = ST_READY;
            end
            default:                           state_nx = ST_READY;
        endcase
    end

    // Group pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load_fall) begin
            ptr <= '0;
        end else if (cap_en) begin
            ptr <= last_grp ? '0 : ptr + 1'b1;
        end
    end

endmodule

// File: rtl/lcd_col_capture.sv
module lcd_col_capture #(
    parameter int NUM_OUT = 240,
    parameter int BUS_W   = 8,
    parameter int PTR_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_en,
    input  logic [PTR_W-1:0]   ptr,
    input  logic               wide,
    input  logic               asc,
    input  logic [BUS_W-1:0]   din,
    output logic [NUM_OUT-1:0] data_q
);

    localparam int NARROW_W = BUS_W / 2;
    localparam int SEL_W    = $clog2(BUS_W);

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_col
        // Fill-order position of this column in each direction
        localparam int FP_ASC  = i;
        localparam int FP_DESC = NUM_OUT - 1 - i;

        logic [PTR_W-1:0] grp;
        logic [SEL_W-1:0] sel;

        always_comb begin
            unique case ({wide, asc})
                2'b11: begin
                    grp = PTR_W'(FP_ASC / BUS_W);
                    sel = SEL_W'(FP_ASC % BUS_W);
                end
                2'b10: begin
                    grp = PTR_W'(FP_DESC / BUS_W);
                    sel = SEL_W'(FP_DESC % BUS_W);
                end
                2'b01: begin
                    grp = PTR_W'(FP_ASC / NARROW_W);
                    sel = SEL_W'(FP_ASC % NARROW_W);
                end
                default: begin
                    grp = PTR_W'(FP_DESC / NARROW_W);
                    sel = SEL_W'(FP_DESC % NARROW_W);
                end
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_q[i] <= 1'b0;
            end else if (cap_en && (ptr == grp)) begin
                data_q[i] <= din[sel];
            end
        end
    end

endmodule

// File: rtl/lcd_col_levels.sv
module lcd_col_levels
    import lcd_col_pkg::*;
#(
    parameter int NUM_OUT = 240
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_fall,
    input  logic [NUM_OUT-1:0]   data_q,
    input  logic                 m_alt,
    input  logic                 disp_on,
    output logic [2*NUM_OUT-1:0] level_o
);

    logic [NUM_OUT-1:0] latch_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (load_fall) begin
            latch_q <= data_q;
        end
    end

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_lvl
        drive_lvl_e lvl;

        always_comb begin
            if (!disp_on) begin
                lvl = LVL_V5;
            end else begin
                unique case ({m_alt, latch_q[i]})
                    2'b11:   lvl = LVL_V0;
                    2'b10:   lvl = LVL_V2;
                    2'b00:   lvl = LVL_V3;
                    default: lvl = LVL_V5;
                endcase
            end
        end

        assign level_o[2*i +: 2] = lvl;
    end

endmodule

// File: rtl/lcd_col_driver.sv
module lcd_col_driver #(
    parameter int NUM_OUT = 240,
    parameter int BUS_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cp,
    input  logic                 load,
    input  logic [BUS_W-1:0]     din,
    input  logic                 bus_wide,
    input  logic                 dir_asc,
    input  logic                 m_alt,
    input  logic                 disp_on,
    inout  wire                  eio_a,
    inout  wire                  eio_b,
    output logic [2*NUM_OUT-1:0] level_o
);

    localparam int PTR_W = $clog2(NUM_OUT / (BUS_W / 2));

    logic               ein_n;
    logic               eout_n;
    logic               cap_en;
    logic               load_fall;
    logic [PTR_W-1:0]   ptr;
    logic [NUM_OUT-1:0] data_q;

    // Enable pin roles follow the fill direction
    assign ein_n = dir_asc ? eio_b : eio_a;
    assign eio_a = dir_asc ? eout_n : 1'bz;
    assign eio_b = dir_asc ? 1'bz : eout_n;

    lcd_col_ctrl #(
        .NUM_OUT (NUM_OUT),
        .BUS_W   (BUS_W),
        .PTR_W   (PTR_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cp        (cp),
        .load      (load),
        .ein_n     (ein_n),
        .wide      (bus_wide),
        .cap_en    (cap_en),
        .ptr       (ptr),
        .eout_n    (eout_n),
        .load_fall (load_fall)
    );

    lcd_col_capture #(
        .NUM_OUT (NUM_OUT),
        .BUS_W   (BUS_W),
        .PTR_W   (PTR_W)
    ) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .ptr    (ptr),
        .wide   (bus_wide),
        .asc    (dir_asc),
        .din    (din),
        .data_q (data_q)
    );

    lcd_col_levels #(
        .NUM_OUT (NUM_OUT)
    ) u_levels (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_fall (load_fall),
        .data_q    (data_q),
        .m_alt     (m_alt),
        .disp_on   (disp_on),
        .level_o   (level_o)
    );

endmodule

// File: rtl/lcd_col_driver_chk.sv
module lcd_col_driver_chk #(
    parameter int NUM_OUT = 240,
    parameter int BUS_W   = 8,
    parameter int PTR_W   = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wide,
    input logic                 m_alt,
    input logic                 disp_on,
    input logic                 ein_n,
    input logic                 eout_n,
    input logic                 load_fall,
    input logic [PTR_W-1:0]     ptr,
    input logic [NUM_OUT-1:0]   data_q,
    input logic [2*NUM_OUT-1:0] level_o
);

    localparam logic [PTR_W-1:0] LAST_WIDE   = PTR_W'(NUM_OUT / BUS_W - 1);
    localparam logic [PTR_W-1:0] LAST_NARROW = PTR_W'(NUM_OUT / (BUS_W / 2) - 1);

    a_r9_disp_off: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_on |-> (level_o == {2*NUM_OUT{1'b1}}));

    a_r6_load_release: assert property (@(posedge clk) disable iff (!rst_n)
        load_fall |=> eout_n);

    a_r5_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!eout_n && !load_fall) |=> $stable(data_q));

    a_r4_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (ein_n && !load_fall) |=> $stable(data_q));

    a_r12_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load_fall |=> $stable(data_q));

    a_r3_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= (bus_wide ? LAST_WIDE : LAST_NARROW));

    a_r7_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_fall |=> ($stable(level_o) || !$stable(m_alt) || !$stable(disp_on)));

endmodule

bind lcd_col_driver lcd_col_driver_chk #(
    .NUM_OUT (NUM_OUT),
    .BUS_W   (BUS_W),
    .PTR_W   (PTR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wide  (bus_wide),
    .m_alt     (m_alt),
    .disp_on   (disp_on),
    .ein_n     (ein_n),
    .eout_n    (eout_n),
    .load_fall (load_fall),
    .ptr       (ptr),
    .data_q    (data_q),
    .level_o   (level_o)
);

// File: tb/test_lcd_col_driver.sv
module test_lcd_col_driver;

    localparam int N = 240;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cp = 1'b0;
    logic         load = 1'b0;
    logic [7:0]   din = 8'h00;
    logic         bs = 1'b1;
    logic         rl = 1'b0;
    logic         m = 1'b1;
    logic         disp = 1'b1;
    logic         ein_drv = 1'b0;
    wire          eio_a;
    wire          eio_b;
    logic [2*N-1:0] level;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    logic expreg [N];
    logic expl   [N];

    assign eio_a = rl ? 1'bz : ein_drv;
    assign eio_b = rl ? ein_drv : 1'bz;

    lcd_col_driver i_lcd_col_driver (
        .clk      (clk),
        .rst_n    (rst_n),
        .cp       (cp),
        .load     (load),
        .din      (din),
        .bus_wide (bs),
        .dir_asc  (rl),
        .m_alt    (m),
        .disp_on  (disp),
        .eio_a    (eio_a),
        .eio_b    (eio_b),
        .level_o  (level)
    );

    always #4 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic eout_pin();
        return rl ? eio_a : eio_b;
    endfunction

    function automatic int code_of(input logic mm, input logic dd, input logic b);
        if (!dd) return 3;
        if (mm) return b ? 0 : 1;
        return b ? 3 : 2;
    endfunction

    task automatic cmp_levels(input string req);
        int bad = -1;
        int a = 0;
        int e = 0;
        for (int i = 0; i < N; i++) begin
            if (bad < 0 && int'(level[2*i +: 2]) != code_of(m, disp, expl[i])) begin
                bad = i;
                a = int'(level[2*i +: 2]);
                e = code_of(m, disp, expl[i]);
            end
        end
        checks++;
        if (bad >= 0) begin
            errors++;
            $display("FAIL %s column %0d actual %0d expected %0d", req, bad + 1, a, e);
        end
    endtask

    task automatic pulse_cp(input logic [7:0] d);
        din = d;
        cp = 1'b1;
        tick(2);
        cp = 1'b0;
        tick(2);
    endtask

    task automatic pulse_load();
        load = 1'b1;
        tick(2);
        load = 1'b0;
        tick(2);
        for (int i = 0; i < N; i++) expl[i] = expreg[i];
    endtask

    function automatic logic [7:0] pattern(input int g, input int cfg, input int pass);
        return 8'((g * 29 + cfg * 71 + pass * 45 + 13) & 255);
    endfunction

    // Capture groups [0, upto) of the current configuration into the model
    task automatic capture_groups(input int upto, input int cfg, input int pass, input string req);
        int w = bs ? 8 : 4;
        int groups = bs ? 30 : 60;
        for (int g = 0; g < upto; g++) begin
            logic [7:0] dg = pattern(g, cfg, pass);
            logic [7:0] drv = bs ? dg : {dg[7:4] | 4'h1, dg[3:0]};
            pulse_cp(drv);
            for (int j = 0; j < w; j++) begin
                int p = g * w + j;
                int idx = rl ? p : N - 1 - p;
                expreg[idx] = dg[j];
            end
            if (g == groups - 2)
                check({req, " enable out high before last group"}, int'(eout_pin()), 1);
        end
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            expreg[i] = 1'b0;
            expl[i] = 1'b0;
        end
        tick(3);
        rst_n = 1'b1;
        tick(2);

        // R11: reset state
        check("R11 enable out after reset", int'(eout_pin()), 1);
        cmp_levels("R11 levels after reset");

        // R4: enable input high blocks capture
        bs = 1'b1;
        rl = 1'b1;
        ein_drv = 1'b1;
        for (int k = 0; k < 5; k++) pulse_cp(8'hFF);
        check("R4 enable out while gated", int'(eout_pin()), 1);
        pulse_load();
        cmp_levels("R4 gated capture left register clear");
        ein_drv = 1'b0;

        // R9: display off
        disp = 1'b0;
        tick(1);
        cmp_levels("R9 display off");
        disp = 1'b1;
        tick(1);

        for (int cfg = 0; cfg < 4; cfg++) begin
            string tag;
            int groups;
            bs = cfg[1];
            rl = cfg[0];
            groups = bs ? 30 : 60;
            tag = bs ? (rl ? "R1" : "R2") : "R3";
            tick(1);
            pulse_load();
            check("R6 enable out after load", int'(eout_pin()), 1);

            capture_groups(groups, cfg, 0, tag);
            check("R5 R10 enable out low when full", int'(eout_pin()), 0);
            pulse_cp(8'h5A);
            check("R5 enable out stays low", int'(eout_pin()), 0);
            pulse_load();
            check("R6 enable out released", int'(eout_pin()), 1);
            for (int mv = 0; mv < 2; mv++) begin
                m = mv[0];
                tick(1);
                cmp_levels({tag, " R8 R5 mapping and decode"});
            end

            // R7: further data clocks do not disturb the latch
            capture_groups(3, cfg, 1, "R7");
            cmp_levels("R7 latch held across data clocks");

            // R12: simultaneous load and data clock
            din = 8'hC3;
            cp = 1'b1;
            load = 1'b1;
            tick(2);
            cp = 1'b0;
            load = 1'b0;
            tick(2);
            for (int i = 0; i < N; i++) expl[i] = expreg[i];
            cmp_levels("R12 load wins over data clock");
            check("R12 enable out after joint edge", int'(eout_pin()), 1);
            capture_groups(groups, cfg, 2, "R12");
            check("R12 full after full count", int'(eout_pin()), 0);
            pulse_load();
            cmp_levels({tag, " R12 refill mapping"});
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule